// File: doc/BRIEF.md
# Strobed Code Latch with 4-to-16 Line Decode

The block holds a 4-bit code and raises one of sixteen output lines that the code selects. A strobe input lets the code register follow the live input. When the strobe is low the register freezes, so the selected line stays put while the input bus is reused for other traffic. A separate inhibit input forces every line to its inactive level at once, and it leaves the held code untouched. When inhibit drops, the line that was selected before comes back.

The code register is clocked in the system clock domain, so the design contains no real latches. On each rising clock edge where `strobe_i` is 1, the register takes `code_i`. On any other edge it keeps its value. Decode, inhibit gating and polarity are combinational from the register and from `inhibit_i`. A parameter chooses whether the selected line is driven 1 and the others 0 (active-high), or the reverse (active-low). Typical uses are address-to-enable fan-out and steering a serial bit to one of many destinations. In the steering case the inhibit input carries the data and the held code picks the target.

Top module: `strobe_decoder`

## Requirements
- R1: After reset the held code is 0000, so line 0 is the selected line until a strobe loads another code.
- R2: On a rising clock edge where `strobe_i` is 1, the held code takes `code_i`. The outputs show the new code from that edge on.
- R3: On a rising clock edge where `strobe_i` is 0, the held code keeps its value, and any change on `code_i` has no effect on `line_o`.
- R4: Code value n, read as plain binary with `code_i[3]` as MSB, selects `line_o[n]`. For example, 0000 selects bit 0 and 1111 selects bit 15.
- R5: With POLARITY = POL_HIGH (the default), the selected line is 1 and all other lines are 0.
- R6: With POLARITY = POL_LOW, the selected line is 0 and all other lines are 1.
- R7: While `inhibit_i` is 1, every line sits at its inactive level in the same cycle. This holds whatever the code and strobe are, and no clock edge is needed.
- R8: Inhibit does not alter the held code. Once `inhibit_i` returns to 0, the line for the held code is active again. A strobe during inhibit still loads the code.
- R9: While `inhibit_i` is 0, exactly one line is at the active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_i | input | 4 | Code to capture; bit 3 is MSB |
| strobe_i | input | 1 | 1: register loads code_i each edge; 0: register holds |
| inhibit_i | input | 1 | 1: all lines forced inactive |
| line_o | output | 16 | Decoded lines, polarity set by POLARITY |

## Verification
A code and strobe applied before a rising edge appear on `line_o` just after that edge, because there is one register in the path. Inhibit has no register in its path and takes effect within the same cycle. The bench drives inputs on the falling edge and samples 1 ns after the following rising edge. This lets each vector see exactly one capture decision. For the inhibit cases, the bench also samples mid-cycle with no edge in between, to show that the forcing acts without a clock edge. Two instances, one of each polarity, receive the same stimulus and are compared against expected values computed in the bench.

// File: rtl/strobe_dec_pkg.sv
package strobe_dec_pkg;
  typedef enum logic {
    POL_LOW  = 1'b0,
    POL_HIGH = 1'b1
  } pol_e;

  localparam int unsigned CODE_W_DEF = 4;
endpackage

// File: rtl/sdec_capture.sv
module sdec_capture #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] held_o
);
  // clocked stand-in for a transparent latch: load while strobe high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       held_o <= '0;
    else if (strobe_i) held_o <= code_i;
  end
endmodule

// File: rtl/sdec_onehot.sv
module sdec_onehot #(
  parameter int unsigned CODE_W = 4,
  localparam int unsigned LINES = 1 << CODE_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [LINES-1:0]  sel_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam logic [CODE_W-1:0] IDX = CODE_W'(i);
    assign sel_o[i] = (code_i == IDX);
  end
endmodule

// File: rtl/sdec_drive.sv
module sdec_drive
  import strobe_dec_pkg::*;
#(
  parameter int unsigned LINES    = 16,
  parameter pol_e        POLARITY = POL_HIGH
) (
  input  logic [LINES-1:0] sel_i,
  input  logic             inhibit_i,
  output logic [LINES-1:0] line_o
);
  logic [LINES-1:0] gated;
  assign gated = inhibit_i ? '0 : sel_i;

  if (POLARITY == POL_HIGH) begin : g_high
    assign line_o = gated;
  end else begin : g_low
    assign line_o = ~gated;
  end
endmodule

// File: rtl/strobe_decoder.sv
module strobe_decoder
  import strobe_dec_pkg::*;
#(
  parameter int unsigned CODE_W   = CODE_W_DEF,
  parameter pol_e        POLARITY = POL_HIGH,
  localparam int unsigned LINES   = 1 << CODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              strobe_i,
  input  logic              inhibit_i,
  output logic [LINES-1:0]  line_o
);
  logic [CODE_W-1:0] held_q;
  logic [LINES-1:0]  sel;

  sdec_capture #(.CODE_W(CODE_W)) u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .code_i   (code_i),
    .held_o   (held_q)
  );

  sdec_onehot #(.CODE_W(CODE_W)) u_onehot (
    .code_i (held_q),
    .sel_o  (sel)
  );

  sdec_drive #(.LINES(LINES), .POLARITY(POLARITY)) u_drive (
    .sel_i     (sel),
    .inhibit_i (inhibit_i),
    .line_o    (line_o)
  );
endmodule

// File: rtl/strobe_decoder_chk.sv
module strobe_decoder_chk
  import strobe_dec_pkg::*;
#(
  parameter int unsigned CODE_W   = 4,
  parameter pol_e        POLARITY = POL_HIGH,
  localparam int unsigned LINES   = 1 << CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] code_i,
  input logic              strobe_i,
  input logic              inhibit_i,
  input logic [LINES-1:0]  line_o,
  input logic [CODE_W-1:0] held_i
);
  localparam logic ACT = (POLARITY == POL_HIGH);
  logic [LINES-1:0] act_lines;
  assign act_lines = ACT ? line_o : ~line_o;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> held_i == $past(code_i));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(held_i));

  p_sel_bit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_i |-> line_o[held_i] == ACT);

  p_force_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |-> act_lines == '0);

  p_keep_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inhibit_i && !strobe_i) |=> held_i == $past(held_i));

  p_one_active_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_i |-> $countones(act_lines) == 1);
endmodule

bind strobe_decoder strobe_decoder_chk #(
  .CODE_W   (CODE_W),
  .POLARITY (POLARITY)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .code_i    (code_i),
  .strobe_i  (strobe_i),
  .inhibit_i (inhibit_i),
  .line_o    (line_o),
  .held_i    (held_q)
);

// File: tb/strobe_decoder_tb.sv
`timescale 1ns/1ps
module strobe_decoder_tb;
  import strobe_dec_pkg::*;

  localparam int W = 4;
  localparam int L = 16;
  localparam int NV = 24;

  // {code[3:0], strobe, inhibit, expected held code[3:0]}
  localparam logic [9:0] VEC [NV] = '{
    {4'd0,  1'b1, 1'b0, 4'd0},  {4'd1,  1'b1, 1'b0, 4'd1},
    {4'd2,  1'b1, 1'b0, 4'd2},  {4'd3,  1'b1, 1'b0, 4'd3},
    {4'd4,  1'b1, 1'b0, 4'd4},  {4'd5,  1'b1, 1'b0, 4'd5},
    {4'd6,  1'b1, 1'b0, 4'd6},  {4'd7,  1'b1, 1'b0, 4'd7},
    {4'd8,  1'b1, 1'b0, 4'd8},  {4'd9,  1'b1, 1'b0, 4'd9},
    {4'd10, 1'b1, 1'b0, 4'd10}, {4'd11, 1'b1, 1'b0, 4'd11},
    {4'd12, 1'b1, 1'b0, 4'd12}, {4'd13, 1'b1, 1'b0, 4'd13},
    {4'd14, 1'b1, 1'b0, 4'd14}, {4'd15, 1'b1, 1'b0, 4'd15},
    {4'd5,  1'b1, 1'b0, 4'd5},  {4'd9,  1'b0, 1'b0, 4'd5},
    {4'd12, 1'b0, 1'b1, 4'd5},  {4'd12, 1'b0, 1'b0, 4'd5},
    {4'd3,  1'b1, 1'b1, 4'd3},  {4'd7,  1'b0, 1'b0, 4'd3},
    {4'd14, 1'b1, 1'b0, 4'd14}, {4'd0,  1'b0, 1'b0, 4'd14}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] code = '0;
  logic         strobe = 1'b0;
  logic         inhibit = 1'b0;
  logic [L-1:0] line_hi, line_lo;
  int           n_chk = 0;
  int           n_fail = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  strobe_decoder #(.CODE_W(W), .POLARITY(POL_HIGH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code), .strobe_i(strobe),
    .inhibit_i(inhibit), .line_o(line_hi)
  );

  strobe_decoder #(.CODE_W(W), .POLARITY(POL_LOW)) u_dut_n (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code), .strobe_i(strobe),
    .inhibit_i(inhibit), .line_o(line_lo)
  );

  function automatic logic [L-1:0] expect_lines(logic [W-1:0] c, logic inh, logic high);
    logic [L-1:0] v;
    v = inh ? '0 : (L'(1) << c);
    return high ? v : ~v;
  endfunction

  task automatic check(string tag, logic [L-1:0] act, logic [L-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %04h expected %04h", tag, act, exp);
    end
  endtask

  task automatic check_pair(string tag, logic [W-1:0] c, logic inh);
    logic [L-1:0] acts;
    check({tag, " R5 high"}, line_hi, expect_lines(c, inh, 1'b1));
    check({tag, " R6 low"},  line_lo, expect_lines(c, inh, 1'b0));
    acts = line_hi;
    if (!inh) begin
      n_chk++;
      if ($countones(acts) != 1) begin
        n_fail++;
        $display("FAIL R9: active count %0d expected 1", $countones(acts));
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 reset", line_hi, expect_lines(4'd0, 1'b0, 1'b1));
    check("R1 reset", line_lo, expect_lines(4'd0, 1'b0, 1'b0));

    for (int i = 0; i < NV; i++) begin
      logic [9:0] v;
      string tag;
      v = VEC[i];
      @(negedge clk);
      code    = v[9:6];
      strobe  = v[5];
      inhibit = v[4];
      @(posedge clk); #1;
      tag = v[4] ? "R7 R8" : (v[5] ? "R2 R4" : "R3 R8");
      check_pair(tag, v[3:0], v[4]);
    end

    // held code is 14, strobe low; inhibit without any edge in between
    @(negedge clk);
    #1 inhibit = 1'b1;
    #1 check_pair("R7 async", 4'd14, 1'b1);
    #1 inhibit = 1'b0;
    #1 check_pair("R8 release", 4'd14, 1'b0);

    // code changes while held: no effect on lines
    code = 4'd1;
    @(posedge clk); #1;
    check_pair("R3 ignore", 4'd14, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule